// File: doc/BRIEF.md
# Prioritized Interrupt Entry and Return Sequencer

This block sits beside a small 16-bit processor core and decides when that core must be interrupted. It does the stack work of interrupt entry and of return-from-interrupt so that the core does not have to. Seven sources are tracked in a pending register. Five of them come from external pins. One is raised internally when the register-context pointer wraps. The last is the trace source, which is always pending. A software-written enable register masks each source.

The current interrupt level is held in an internal status register. Level 0 means no interrupt is active, and level n+1 means source n is being served. A source is accepted only when its enable bit is set and its level is strictly above the current one.

On entry, the sequencer does the following steps. It pushes the status word and then the return PC through a single word-wide memory port with a ready handshake, pre-decrementing the stack pointer before each write. It then raises the level, moves the context pointer down by two and loads the vector address. On a return request it reverses these steps: it moves the context pointer up by two, then pops the PC and then the status word, post-incrementing the stack pointer after each read. While a sequence runs, `busy_o` stalls the core. A one-cycle `done_o` marks the cycle in which `pc_o` holds the new program counter.

Top module: `irq_entry_seq`

## Requirements
- R1: `status_o` bit 7 always reads 0 and bit 5 (trace source) always reads 1. Bits 0-3 and 6 are set by external inputs `irq_i[3:0]` and `irq_i[4]` respectively. Bit 4 is set by a context pointer wrap. A set bit stays set until a 1 is written to the same bit of `pend_clr_i`. If a set and a clear arrive in the same cycle, the set wins.
- R2: `ien_we_i` loads bits 6:0 of `ien_wdata_i` into the enable register. `enable_o` bit 7 always reads 0. A pending source whose enable bit is 0 is never taken.
- R3: Among the enabled pending sources, the one with the highest number is taken. A source n is taken only if n+1 is greater than the current level. A source at the same level as the current one, or below it, is held off.
- R4: On entry, the status word `{12'b0, level}` is written at SP-1, then the return PC (`pc_i`, sampled when the request is accepted) is written at SP-2. The sequence leaves SP lower by 2.
- R5: When an entry completes, `level_o` = n+1, `ctx_o` is lower by 2, and `pc_o` = VEC_BASE + 2n (VEC_BASE defaults to 0x0010). `done_o` is high for exactly one cycle, and `busy_o` is high from acceptance until that cycle.
- R6: On `reti_i`, `ctx_o` rises by 2. The PC is then read from SP, then the status is read from SP+1. `pc_o` and `level_o` take the popped values, and SP ends higher by 2. `reti_i` has priority over a pending interrupt.
- R7: A wrap of the 8-bit context pointer, whether it goes below 0 or above 255, sets pending bit 4. That bit stays set until software clears it.
- R8: The trace source 5 is taken as soon as its enable bit is set and the level is below 6.
- R9: Requests arriving while a sequence runs are latched only. Arbitration happens again once the block is idle and the `done_o` cycle has passed, so a latched higher source then nests.
- R10: A memory word moves only in a cycle in which `mem_req_o` and `mem_ready_i` are both high. While ready is low, the request and SP hold.
- R11: After reset, the following values hold: level 0, SP = SP_INIT (0x0100), context pointer = CTX_INIT, enable 0, status 0x20, and `busy_o` and `done_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | 5 | External requests; bits 3:0 go to sources 3:0, bit 4 to source 6 |
| ien_we_i | input | 1 | Enable register write strobe |
| ien_wdata_i | input | 8 | Enable register write data |
| pend_clr_i | input | 8 | Write-1-to-clear mask for pending bits |
| status_o | output | 8 | Pending status |
| enable_o | output | 8 | Enable register |
| reti_i | input | 1 | Return-from-interrupt request |
| pc_i | input | 16 | Core return PC, sampled when an interrupt is accepted |
| busy_o | output | 1 | Sequencer running; core must stall |
| done_o | output | 1 | One-cycle pulse; `pc_o` is valid |
| pc_o | output | 16 | New program counter |
| level_o | output | 4 | Current interrupt level |
| sp_o | output | 16 | Stack pointer |
| ctx_o | output | 8 | Register-context pointer |
| mem_req_o | output | 1 | Stack memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 16 | Stack word address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid with `mem_ready_i` |
| mem_ready_i | input | 1 | Memory accepts or returns a word this cycle |

## Verification
A wrong level or a wrong arbitration result shows up within a few cycles of a pending request. The request is then either taken when it should be held off, or held off when it should be taken, and the error can be seen on `busy_o` and on the vector in `pc_o`. A stack pointer that is off by one is exposed at the next return, because `pc_o` and `level_o` then come back with the wrong words; the checks on stack memory contents after each entry catch it even sooner. A context pointer fault appears directly on `ctx_o` at `done_o`, and also as a missing or unexpected pending bit 4 when the pointer wraps.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int unsigned NSRC      = 7;
  localparam int unsigned SRC_CTX   = 4;
  localparam int unsigned SRC_TRACE = 5;
  localparam int unsigned NEXT      = 5;
  localparam int unsigned IDW       = $clog2(NSRC);

  typedef enum logic [2:0] {
    S_IDLE,
    S_PUSH_ST,
    S_PUSH_PC,
    S_ENTER,
    S_RET_CTX,
    S_POP_PC,
    S_POP_ST
  } seq_state_e;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
  import irq_seq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NEXT-1:0] irq_i,
  input  logic            ctx_wrap_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i == SRC_TRACE) begin : g_trace
      logic unused_clr;
      assign unused_clr = clr_i[i];
      assign pend_o[i]  = 1'b1;
    end else begin : g_flop
      logic set_w;
      logic q;
      if (i == SRC_CTX) begin : g_ctx
        assign set_w = ctx_wrap_i;
      end else begin : g_ext
        localparam int E = (i < SRC_CTX) ? i : i - 2;
        assign set_w = irq_i[E];
      end
      // set wins over a same-cycle clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else         q <= set_w | (q & ~clr_i[i]);
      end
      assign pend_o[i] = q;
    end
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_seq_pkg::*;
#(
  parameter int unsigned LW = 4
) (
  input  logic [NSRC-1:0] req_i,
  input  logic [LW-1:0]   lvl_i,
  output logic            valid_o,
  output logic [IDW-1:0]  id_o
);
  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req_i[i] && ((i + 1) > int'(lvl_i))) begin
        valid_o = 1'b1;
        id_o    = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_ctx_ptr.sv
module irq_ctx_ptr #(
  parameter int unsigned    CW   = 8,
  parameter int unsigned    STEP = 2,
  parameter logic [CW-1:0]  INIT = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dec_i,
  input  logic          inc_i,
  output logic [CW-1:0] ctx_o,
  output logic          wrap_o
);
  logic [CW-1:0] ctx_q;
  logic [CW:0]   add_w, sub_w;

  assign add_w  = {1'b0, ctx_q} + (CW+1)'(STEP);
  assign sub_w  = {1'b0, ctx_q} - (CW+1)'(STEP);
  assign wrap_o = (inc_i & add_w[CW]) | (dec_i & sub_w[CW]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ctx_q <= INIT;
    else if (dec_i) ctx_q <= sub_w[CW-1:0];
    else if (inc_i) ctx_q <= add_w[CW-1:0];
  end
  assign ctx_o = ctx_q;
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int unsigned   DW       = 16,
  parameter int unsigned   CW       = 8,
  parameter int unsigned   LW       = 4,
  parameter logic [DW-1:0] SP_INIT  = 16'h0100,
  parameter logic [CW-1:0] CTX_INIT = 8'd16,
  parameter logic [DW-1:0] VEC_BASE = 16'h0010
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NEXT-1:0] irq_i,
  input  logic            ien_we_i,
  input  logic [7:0]      ien_wdata_i,
  input  logic [7:0]      pend_clr_i,
  output logic [7:0]      status_o,
  output logic [7:0]      enable_o,
  input  logic            reti_i,
  input  logic [DW-1:0]   pc_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [DW-1:0]   pc_o,
  output logic [LW-1:0]   level_o,
  output logic [DW-1:0]   sp_o,
  output logic [CW-1:0]   ctx_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [DW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic [DW-1:0]   mem_rdata_i,
  input  logic            mem_ready_i
);
  seq_state_e      state_q;
  logic [NSRC-1:0] pend_w, ien_q;
  logic [IDW-1:0]  id_q, arb_id_w;
  logic            arb_valid_w, ctx_wrap_w;
  logic [DW-1:0]   sp_q, pc_q, ret_pc_q;
  logic [LW-1:0]   lvl_q;
  logic            done_q;
  logic            idle_w, take_w, reti_go_w, is_push_w;
  logic            unused_hi;

  assign unused_hi = ^{ien_wdata_i[7], pend_clr_i[7]};

  irq_pend_reg u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_i      (irq_i),
    .ctx_wrap_i (ctx_wrap_w),
    .clr_i      (pend_clr_i[NSRC-1:0]),
    .pend_o     (pend_w)
  );

  irq_prio_arb #(.LW(LW)) u_arb (
    .req_i   (pend_w & ien_q),
    .lvl_i   (lvl_q),
    .valid_o (arb_valid_w),
    .id_o    (arb_id_w)
  );

  irq_ctx_ptr #(.CW(CW), .STEP(2), .INIT(CTX_INIT)) u_ctx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dec_i  (state_q == S_ENTER),
    .inc_i  (state_q == S_RET_CTX),
    .ctx_o  (ctx_o),
    .wrap_o (ctx_wrap_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ien_q <= '0;
    else if (ien_we_i) ien_q <= ien_wdata_i[NSRC-1:0];
  end

  // no arbitration in the done cycle: the core needs one cycle to present pc_i
  assign idle_w    = (state_q == S_IDLE) && !done_q;
  assign reti_go_w = idle_w && reti_i;
  assign take_w    = idle_w && !reti_i && arb_valid_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      id_q     <= '0;
      ret_pc_q <= '0;
      sp_q     <= SP_INIT;
      pc_q     <= '0;
      lvl_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (reti_go_w) state_q <= S_RET_CTX;
          else if (take_w) begin
            id_q     <= arb_id_w;
            ret_pc_q <= pc_i;
            state_q  <= S_PUSH_ST;
          end
        end
        S_PUSH_ST: if (mem_ready_i) begin
          sp_q    <= sp_q - DW'(1);
          state_q <= S_PUSH_PC;
        end
        S_PUSH_PC: if (mem_ready_i) begin
          sp_q    <= sp_q - DW'(1);
          state_q <= S_ENTER;
        end
        S_ENTER: begin
          lvl_q   <= LW'(id_q) + LW'(1);
          pc_q    <= VEC_BASE + DW'({id_q, 1'b0});
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        S_RET_CTX: state_q <= S_POP_PC;
        S_POP_PC: if (mem_ready_i) begin
          pc_q    <= mem_rdata_i;
          sp_q    <= sp_q + DW'(1);
          state_q <= S_POP_ST;
        end
        S_POP_ST: if (mem_ready_i) begin
          lvl_q   <= mem_rdata_i[LW-1:0];
          sp_q    <= sp_q + DW'(1);
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign is_push_w   = (state_q == S_PUSH_ST) || (state_q == S_PUSH_PC);
  assign mem_req_o   = is_push_w || (state_q == S_POP_PC) || (state_q == S_POP_ST);
  assign mem_we_o    = is_push_w;
  assign mem_addr_o  = is_push_w ? sp_q - DW'(1) : sp_q;
  assign mem_wdata_o = (state_q == S_PUSH_ST) ? DW'(lvl_q) : ret_pc_q;

  assign busy_o   = (state_q != S_IDLE);
  assign done_o   = done_q;
  assign pc_o     = pc_q;
  assign level_o  = lvl_q;
  assign sp_o     = sp_q;
  assign status_o = {1'b0, pend_w};
  assign enable_o = {1'b0, ien_q};
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [7:0]    status_o,
  input logic [7:0]    enable_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic          mem_ready_i,
  input logic [DW-1:0] sp_o
);
  a_r1_fixed_status_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[7] && status_o[5]);

  a_r2_enable_bit7_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_o[7]);

  a_r4_push_lowers_sp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_ready_i |=> sp_o == $past(sp_o) - DW'(1));

  a_r6_pop_raises_sp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o && mem_ready_i |=> sp_o == $past(sp_o) + DW'(1));

  a_r10_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(sp_o));

  a_r10_req_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r5_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r9_gap_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !mem_req_o);
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .status_o    (status_o),
  .enable_o    (enable_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_ready_i (mem_ready_i),
  .sp_o        (sp_o)
);

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] VB = 16'h0010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  irq = '0;
  logic        ien_we = 1'b0;
  logic [7:0]  ien_wdata = '0;
  logic [7:0]  pend_clr = '0;
  logic [7:0]  status, enable;
  logic        reti = 1'b0;
  logic [15:0] pc_in = '0;
  logic        busy, done;
  logic [15:0] pc_out, sp;
  logic [3:0]  level;
  logic [7:0]  ctx;
  logic        mem_req, mem_we, mem_ready;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic [15:0] mem [0:255];
  bit          rand_ready = 1'b0;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_entry_seq #(.CTX_INIT(8'd3)) uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .ien_we_i(ien_we),
    .ien_wdata_i(ien_wdata), .pend_clr_i(pend_clr), .status_o(status),
    .enable_o(enable), .reti_i(reti), .pc_i(pc_in), .busy_o(busy),
    .done_o(done), .pc_o(pc_out), .level_o(level), .sp_o(sp), .ctx_o(ctx),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready)
  );

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_req && mem_we && mem_ready) mem[mem_addr[7:0]] <= mem_wdata;

  initial mem_ready = 1'b1;
  always @(negedge clk) if (rand_ready) mem_ready <= ($urandom % 3) != 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int winner(logic [6:0] en, logic [4:0] ext, int lvl);
    logic [6:0] src;
    int w;
    src = {ext[4], 2'b00, ext[3:0]};
    w = -1;
    for (int i = 0; i < 7; i++) if (src[i] && en[i] && (i + 1) > lvl) w = i;
    return w;
  endfunction

  task automatic write_ien(logic [7:0] v);
    @(negedge clk); ien_we = 1'b1; ien_wdata = v;
    @(negedge clk); ien_we = 1'b0;
  endtask

  task automatic clear_pend(logic [7:0] v);
    @(negedge clk); pend_clr = v;
    @(negedge clk); pend_clr = '0;
  endtask

  task automatic pulse_irq(logic [4:0] m);
    @(negedge clk); irq = m;
    @(negedge clk); irq = '0;
  endtask

  task automatic wait_done(string tag);
    bit ok;
    ok = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
    chk({tag, " done seen"}, ok, 1'b1);
  endtask

  task automatic do_reti();
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0;
  endtask

  task automatic expect_idle(string tag, int cycles);
    bit seen;
    seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (busy) seen = 1'b1;
    end
    chk(tag, seen, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 busy", busy, 0);
    chk("R11 done", done, 0);
    chk("R11 status", status, 8'h20);
    chk("R11 enable", enable, 0);
    chk("R11 level", level, 0);
    chk("R11 sp", sp, 16'h0100);
    chk("R11 ctx", ctx, 8'd3);
    rst_n = 1'b1;

    // R2 enable register, bit 7 reads zero
    write_ien(8'hDF); chk("R2 enable write", enable, 8'h5F);
    write_ien(8'h80); chk("R2 enable bit7", enable, 8'h00);

    // R2 masked source not taken, R1 sticky then cleared
    pulse_irq(5'b00100);
    expect_idle("R2 masked not taken", 15);
    chk("R1 pending latched", status, 8'h24);
    clear_pend(8'h04);
    chk("R1 pending cleared", status, 8'h20);
    @(negedge clk); irq = 5'b00010; pend_clr = 8'h02;
    @(negedge clk); pend_clr = '0;
    chk("R1 set wins over clear", status[1], 1'b1);
    irq = '0;
    clear_pend(8'h02);
    chk("R1 clear after release", status[1], 1'b0);

    // R4 R5 first entry from level 0
    rand_ready = 1'b1;
    pc_in = 16'hA5A0;
    write_ien(8'h04);
    pulse_irq(5'b00100);
    wait_done("R5 src2");
    chk("R5 vector src2", pc_out, VB + 16'd4);
    chk("R5 level src2", level, 4'd3);
    chk("R5 ctx minus 2", ctx, 8'd1);
    chk("R4 sp after entry", sp, 16'h00FE);
    chk("R4 status word pushed", mem[8'hFF], 16'h0000);
    chk("R4 return pc pushed", mem[8'hFE], 16'hA5A0);

    // R3 lower and equal priority held off
    write_ien(8'h47);
    pulse_irq(5'b00010);
    expect_idle("R3 lower and same level blocked", 15);

    // R3 R7 nested higher source, context wraps below zero
    pc_in = 16'h1234;
    pulse_irq(5'b10000);
    wait_done("R3 src6 nest");
    chk("R3 vector src6", pc_out, VB + 16'd12);
    chk("R3 level src6", level, 4'd7);
    chk("R7 ctx wrap down", ctx, 8'd255);
    chk("R4 nested sp", sp, 16'h00FC);
    chk("R4 nested status word", mem[8'hFD], 16'h0003);
    chk("R4 nested pc", mem[8'hFC], 16'h1234);
    chk("R7 wrap sets source4", status[4], 1'b1);
    repeat (5) @(negedge clk);
    chk("R7 source4 sticky", status[4], 1'b1);
    clear_pend(8'h50);
    chk("R7 source4 cleared", status[4], 1'b0);

    // R6 return from nested level, context wraps above max
    do_reti();
    wait_done("R6 reti nested");
    chk("R6 pc popped", pc_out, 16'h1234);
    chk("R6 level restored", level, 4'd3);
    chk("R6 sp restored", sp, 16'h00FE);
    chk("R6 ctx plus 2", ctx, 8'd1);
    chk("R7 wrap up sets source4", status[4], 1'b1);
    clear_pend(8'h16);
    do_reti();
    wait_done("R6 reti outer");
    chk("R6 pc outer", pc_out, 16'hA5A0);
    chk("R6 level outer", level, 4'd0);
    chk("R6 sp outer", sp, 16'h0100);
    chk("R6 ctx outer", ctx, 8'd3);

    // R9 request during a sequence is latched, then nests
    write_ien(8'h48);
    pc_in = 16'h3000;
    pulse_irq(5'b01000);
    pulse_irq(5'b10000);
    wait_done("R9 first");
    chk("R9 first vector", pc_out, VB + 16'd6);
    chk("R9 first level", level, 4'd4);
    pc_in = 16'h3100;
    wait_done("R9 second");
    chk("R9 second vector", pc_out, VB + 16'd12);
    chk("R9 second level", level, 4'd7);
    write_ien(8'h00);
    clear_pend(8'h58);
    do_reti();
    wait_done("R9 reti1");
    chk("R9 reti1 pc", pc_out, 16'h3100);
    chk("R9 reti1 level", level, 4'd4);
    do_reti();
    wait_done("R9 reti2");
    chk("R9 reti2 pc", pc_out, 16'h3000);
    chk("R9 reti2 level", level, 4'd0);
    clear_pend(8'h10);

    // R8 trace source
    pc_in = 16'h4000;
    write_ien(8'h20);
    wait_done("R8 trace");
    chk("R8 trace vector", pc_out, VB + 16'd10);
    chk("R8 trace level", level, 4'd6);
    write_ien(8'h00);
    do_reti();
    wait_done("R8 reti");
    chk("R8 reti level", level, 4'd0);
    chk("R8 reti pc", pc_out, 16'h4000);

    // R3 R5 R6 R10 random patterns under random ready
    for (int it = 0; it < 60; it++) begin
      logic [6:0]  en;
      logic [4:0]  m;
      logic [15:0] pcv;
      int w;
      en  = 7'($urandom) & 7'h4F;
      m   = 5'($urandom);
      pcv = 16'($urandom);
      w   = winner(en, m, 0);
      clear_pend(8'h5F);
      pc_in = pcv;
      write_ien({1'b0, en});
      pulse_irq(m);
      if (w < 0) begin
        expect_idle("R2 random no winner", 10);
        write_ien(8'h00);
      end else begin
        wait_done("R3 random entry");
        chk("R3 random vector", pc_out, VB + 16'(2 * w));
        chk("R5 random level", level, 4'(w + 1));
        chk("R10 random sp", sp, 16'h00FE);
        chk("R4 random pushed pc", mem[8'hFE], pcv);
        write_ien(8'h00);
        clear_pend(8'h5F);
        do_reti();
        wait_done("R6 random reti");
        chk("R6 random pc", pc_out, pcv);
        chk("R6 random level", level, 4'd0);
        chk("R6 random sp", sp, 16'h0100);
        chk("R6 random ctx", ctx, 8'd3);
      end
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule